// File: doc/BRIEF.md
# Multi-Lane Sample Queue and FFT Feeder

This block is the corner-turning front end of a wideband spectrum pipeline. Each capture clock, a wide bus delivers one sample per lane. Every lane is written into a queue of its own, and each queue collects the raw real samples of one independent transform. Once every queue holds a full set of `POINTS` samples, the block drains all queues together at half the capture rate. Each read cycle takes two consecutive samples from every queue.

The words read from the queues are paired onto shared transform cores. The even-numbered queue of a pair drives a core's real input and the odd-numbered queue drives its imaginary input. A single complex transform therefore carries two real streams. A valid strobe marks each output word, and a frame-start pulse marks the first word of every set.

The half-rate side is an alternating enable on the capture clock, so there is no clock crossing. The intended configuration is 16 lanes of 8-bit samples with 1024-point sets. The default `POINTS` is smaller, which keeps the storage modest.

Top module: `corner_turn_feeder`

## Requirements
- R1: Lane j of `cap_data_i` (bits `[j*SAMPLE_W +: SAMPLE_W]`) is appended to queue j on every cycle with `cap_valid_i` high, and each queue returns its samples in arrival order.
- R2: Bus contents on cycles with `cap_valid_i` low are ignored and never show up in any output word.
- R3: A frame starts only when every queue already holds at least `POINTS` unread samples. `sof_o` is high with the first word of a frame and at no other time.
- R4: When no frame is in progress and the queues hold at least `POINTS` samples, the first word of the next frame appears within two cycles.
- R5: A frame consists of exactly `POINTS/2` words. `valid_o` is never high on two consecutive cycles, and the words of one frame are exactly two cycles apart.
- R6: Each output word carries two samples of one queue: the earlier sample in bits `[2*SAMPLE_W-1:SAMPLE_W]` and the later one in bits `[SAMPLE_W-1:0]`.
- R7: Core k receives queue 2k on `core_re_o[k*2*SAMPLE_W +: 2*SAMPLE_W]` and queue 2k+1 on `core_im_o[k*2*SAMPLE_W +: 2*SAMPLE_W]`.
- R8: While and directly after `rst_ni` is low, `valid_o`, `sof_o` and all output words are zero.
- R9: With at most one sample per lane per cycle, no write ever meets a full queue, because each queue holds two sets.
- R10: Output words hold their value on every cycle that `valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Capture clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cap_valid_i | input | 1 | Capture bus carries a sample on every lane |
| cap_data_i | input | LANES*SAMPLE_W | One sample per lane, lane j in bits [j*SAMPLE_W +: SAMPLE_W] |
| core_re_o | output | LANES/2*2*SAMPLE_W | Real-input words, one per core |
| core_im_o | output | LANES/2*2*SAMPLE_W | Imaginary-input words, one per core |
| valid_o | output | 1 | Output words are new this cycle |
| sof_o | output | 1 | First word of a frame |

## Verification
A sample captured at one rising edge counts toward the frame-start decision at the next edge. A frame begins at the first read-enabled edge after that, which is one or two edges later. Output words are registered at the read edge, so they appear one edge after the read.

The bench samples everything on the falling edge. In each cycle it first retires the words the design has just presented and only then adds the sample captured at the same edge. Its pending count therefore equals the depth the design used for its decision, and the two-cycle start window and the two-cycle word spacing are measured against that count.

// File: rtl/corner_feed_pkg.sv
package corner_feed_pkg;
  typedef enum logic {
    FR_IDLE = 1'b0,
    FR_RUN  = 1'b1
  } frame_state_t;
endpackage

// File: rtl/feed_lane_store.sv
module feed_lane_store #(
  parameter int SAMPLE_W = 8,
  parameter int DEPTH    = 128,
  localparam int HALF    = DEPTH / 2,
  localparam int IW      = $clog2(HALF)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic                  wr_bank_i,
  input  logic [IW-1:0]         wr_idx_i,
  input  logic [SAMPLE_W-1:0]   wr_data_i,
  input  logic                  rd_en_i,
  input  logic [IW-1:0]         rd_idx_i,
  output logic [2*SAMPLE_W-1:0] word_o
);
  // even addresses hold earlier samples, odd the later ones
  logic [SAMPLE_W-1:0] bank_e [HALF];
  logic [SAMPLE_W-1:0] bank_o [HALF];
  logic [2*SAMPLE_W-1:0] word_q;

  always_ff @(posedge clk_i) begin
    if (wr_en_i && !wr_bank_i) bank_e[wr_idx_i] <= wr_data_i;
    if (wr_en_i &&  wr_bank_i) bank_o[wr_idx_i] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      word_q <= '0;
    else if (rd_en_i) word_q <= {bank_e[rd_idx_i], bank_o[rd_idx_i]};
  end

  assign word_o = word_q;

  // R10
  word_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(word_o));
endmodule

// File: rtl/feed_frame_ctl.sv
module feed_frame_ctl
  import corner_feed_pkg::*;
#(
  parameter int POINTS = 64,
  parameter int DEPTH  = 128,
  localparam int PW    = $clog2(DEPTH),
  localparam int IW    = PW - 1,
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int RPF   = POINTS / 2,
  localparam int FW    = $clog2(RPF)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_valid_i,
  output logic          wr_en_o,
  output logic          wr_bank_o,
  output logic [IW-1:0] wr_idx_o,
  output logic          rd_go_o,
  output logic [IW-1:0] rd_idx_o,
  output logic          valid_o,
  output logic          sof_o
);
  frame_state_t  state_q;
  logic [PW-1:0] wr_ptr_q;
  logic [IW-1:0] rd_ptr_q;
  logic [CW-1:0] count_q;
  logic [FW-1:0] rd_cnt_q;
  logic          phase_q;
  logic          valid_q, sof_q;
  logic          set_ready, rd_go, first_rd;

  assign set_ready = count_q >= CW'(POINTS);
  // read slot every other cycle; a running frame never waits
  assign rd_go     = phase_q && (state_q == FR_RUN || set_ready);
  assign first_rd  = rd_go && state_q == FR_IDLE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= FR_IDLE;
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
      rd_cnt_q <= '0;
      phase_q  <= 1'b0;
      valid_q  <= 1'b0;
      sof_q    <= 1'b0;
    end else begin
      phase_q <= !phase_q;
      valid_q <= rd_go;
      sof_q   <= first_rd;
      if (cap_valid_i) wr_ptr_q <= wr_ptr_q + PW'(1);
      count_q <= count_q + CW'(cap_valid_i) - (rd_go ? CW'(2) : CW'(0));
      if (rd_go) begin
        rd_ptr_q <= rd_ptr_q + IW'(1);
        if (rd_cnt_q == FW'(RPF - 1)) begin
          rd_cnt_q <= '0;
          state_q  <= FR_IDLE;
        end else begin
          rd_cnt_q <= rd_cnt_q + FW'(1);
          state_q  <= FR_RUN;
        end
      end
    end
  end

  assign wr_en_o   = cap_valid_i;
  assign wr_bank_o = wr_ptr_q[0];
  assign wr_idx_o  = wr_ptr_q[PW-1:1];
  assign rd_go_o   = rd_go;
  assign rd_idx_o  = rd_ptr_q;
  assign valid_o   = valid_q;
  assign sof_o     = sof_q;

  // R9
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_valid_i |-> count_q < CW'(DEPTH));
  // R5
  half_rate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);
  // R3
  sof_with_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_q |-> valid_q);
  // R3
  sof_full_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_q |-> $past(count_q) >= CW'(POINTS));
endmodule

// File: rtl/corner_turn_feeder.sv
module corner_turn_feeder #(
  parameter int LANES    = 16,
  parameter int SAMPLE_W = 8,
  parameter int POINTS   = 64,
  localparam int CORES   = LANES / 2,
  localparam int WORD_W  = 2 * SAMPLE_W,
  localparam int DEPTH   = 2 * POINTS,
  localparam int IW      = $clog2(DEPTH / 2)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      cap_valid_i,
  input  logic [LANES*SAMPLE_W-1:0] cap_data_i,
  output logic [CORES*WORD_W-1:0]   core_re_o,
  output logic [CORES*WORD_W-1:0]   core_im_o,
  output logic                      valid_o,
  output logic                      sof_o
);
  logic          wr_en, wr_bank, rd_go;
  logic [IW-1:0] wr_idx, rd_idx;
  logic [WORD_W-1:0] lane_word [LANES];

  feed_frame_ctl #(.POINTS(POINTS), .DEPTH(DEPTH)) u_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cap_valid_i (cap_valid_i),
    .wr_en_o     (wr_en),
    .wr_bank_o   (wr_bank),
    .wr_idx_o    (wr_idx),
    .rd_go_o     (rd_go),
    .rd_idx_o    (rd_idx),
    .valid_o     (valid_o),
    .sof_o       (sof_o)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    feed_lane_store #(.SAMPLE_W(SAMPLE_W), .DEPTH(DEPTH)) u_store (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_en),
      .wr_bank_i (wr_bank),
      .wr_idx_i  (wr_idx),
      .wr_data_i (cap_data_i[l*SAMPLE_W +: SAMPLE_W]),
      .rd_en_i   (rd_go),
      .rd_idx_i  (rd_idx),
      .word_o    (lane_word[l])
    );
  end

  for (genvar k = 0; k < CORES; k++) begin : g_core
    assign core_re_o[k*WORD_W +: WORD_W] = lane_word[2*k];
    assign core_im_o[k*WORD_W +: WORD_W] = lane_word[2*k+1];
  end

  // R10
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(core_re_o) && $stable(core_im_o));
endmodule

// File: tb/tb_corner_turn_feeder.sv
`timescale 1ns/1ps
module tb_corner_turn_feeder;
  localparam int LANES = 16;
  localparam int SW    = 8;
  localparam int P     = 64;
  localparam int CORES = LANES / 2;
  localparam int WW    = 2 * SW;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cap_valid = 1'b0;
  logic [LANES*SW-1:0] cap_data = '0;
  logic [CORES*WW-1:0] core_re, core_im;
  logic valid, sof;

  always #2.5 clk = !clk;

  corner_turn_feeder #(.LANES(LANES), .SAMPLE_W(SW), .POINTS(P)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .cap_valid_i(cap_valid), .cap_data_i(cap_data),
    .core_re_o(core_re), .core_im_o(core_im), .valid_o(valid), .sof_o(sof));

  int n_chk = 0, n_fail = 0;
  logic [SW-1:0] mdl_q [LANES][$];
  logic pend_v = 1'b0;
  logic [LANES*SW-1:0] pend_d = '0;
  bit active = 0;
  int words = 0, wait_cnt = 0, cyc = 0, last_v = 0, frames = 0;
  logic [CORES*WW-1:0] prev_re = '0, prev_im = '0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [WW-1:0] lane_word(input int l);
    if (l % 2 == 0) return core_re[(l/2)*WW +: WW];
    else            return core_im[(l/2)*WW +: WW];
  endfunction

  task automatic observe();
    int pb;
    cyc++;
    pb = mdl_q[0].size();
    if (sof) begin
      // R3
      chk(!active && pb >= P, "R3 start without full set", 64'(pb), 64'(P));
      // R4
      chk(wait_cnt <= 1, "R4 start latency", 64'(wait_cnt), 64'd1);
      chk(valid, "R3 sof without word", 64'(valid), 64'd1);
      active = 1; words = 0; wait_cnt = 0; frames++;
    end else if (!active && pb >= P) begin
      wait_cnt++;
      if (wait_cnt == 2) chk(0, "R4 frame did not start", 64'(wait_cnt), 64'd1);
    end else wait_cnt = 0;
    if (valid) begin
      // R5
      chk(active, "R5 word outside frame", 64'(active), 64'd1);
      if (words > 0) chk(cyc - last_v == 2, "R5 word spacing", 64'(cyc - last_v), 64'd2);
      last_v = cyc;
      words++;
      for (int l = 0; l < LANES; l++) begin
        logic [WW-1:0] exp;
        if (mdl_q[l].size() < 2) begin
          chk(0, "R1 word with empty model", 64'(mdl_q[l].size()), 64'd2);
        end else begin
          exp[WW-1:SW] = mdl_q[l].pop_front();
          exp[SW-1:0]  = mdl_q[l].pop_front();
          // R1 R2 R6 R7
          chk(lane_word(l) == exp, "R6/R7 lane word", 64'(lane_word(l)), 64'(exp));
        end
      end
      if (words == P / 2) active = 0;
    end else begin
      // R10
      chk(core_re == prev_re && core_im == prev_im, "R10 hold", 64'(core_re), 64'(prev_re));
    end
    prev_re = core_re;
    prev_im = core_im;
    if (pend_v)
      for (int l = 0; l < LANES; l++) mdl_q[l].push_back(pend_d[l*SW +: SW]);
  endtask

  task automatic tick(input logic v, input logic [LANES*SW-1:0] d);
    @(negedge clk);
    observe();
    cap_valid = v;
    cap_data  = d;
    pend_v    = v;
    pend_d    = d;
  endtask

  function automatic logic [LANES*SW-1:0] rnd_bus();
    logic [LANES*SW-1:0] b;
    for (int i = 0; i < LANES*SW/32; i++) b[i*32 +: 32] = $urandom;
    return b;
  endfunction

  function automatic logic [LANES*SW-1:0] dir_bus(input int n);
    logic [LANES*SW-1:0] b;
    for (int l = 0; l < LANES; l++) b[l*SW +: SW] = SW'(l * 16 + n);
    return b;
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R8
    chk(valid == 0, "R8 valid in reset", 64'(valid), 0);
    chk(sof == 0, "R8 sof in reset", 64'(sof), 0);
    chk(core_re == '0 && core_im == '0, "R8 words in reset", 64'(core_re), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(valid == 0 && sof == 0 && core_re == '0, "R8 after reset", 64'(valid), 0);
    prev_re = core_re; prev_im = core_im;

    // directed: one short of a set, with garbage gaps, then the last sample
    for (int n = 0; n < P - 1; n++) begin
      tick(1'b1, dir_bus(n));
      if (n % 7 == 3) tick(1'b0, {LANES{8'hA5}});  // R2
    end
    repeat (12) tick(1'b0, {LANES{8'h5A}});
    chk(frames == 0, "R3 frame before full set", 64'(frames), 0);
    tick(1'b1, dir_bus(P - 1));
    repeat (P + 8) tick(1'b0, '1);
    chk(frames == 1 && !active, "R5 directed frame complete", 64'(frames), 64'd1);

    // random bursty traffic
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(99) < 70) tick(1'b1, rnd_bus());
      else                         tick(1'b0, rnd_bus());
    end
    // full-rate streaming, queues must never overflow (R9)
    for (int i = 0; i < 6 * P; i++) tick(1'b1, rnd_bus());
    // drain
    for (int i = 0; i < 4 * P && (active || mdl_q[0].size() >= P); i++) tick(1'b0, rnd_bus());
    repeat (4) tick(1'b0, rnd_bus());
    chk(frames > 20, "R1 frames streamed", 64'(frames), 64'd21);
    chk(mdl_q[0].size() < P && !active, "R9 nothing stranded", 64'(mdl_q[0].size()), 64'(P - 1));
    summary();
    $finish;
  end
endmodule